// File: doc/BRIEF.md
# Effective Address Generator with Interlock Detection

The block forms a 32-bit effective address for a memory operand from three parts: a base register value, an index register value shifted left by a scale code, and a displacement. The displacement can be empty, a sign-extended byte, or a full word. Each cycle a request arrives with the register numbers and their values, already read from the register file. The result is registered: the address and its valid strobe appear on the clock edge after the request is accepted.

At the same time the block compares the register numbers of the request against the destination written by the instruction issued in the previous cycle. A match means the register value presented is stale. The block then raises a stall request in the same cycle and produces no address. The issuing stage re-presents the request on the next cycle with the updated value. A mode input selects whether only the base register is checked or both base and index. The index slot can never name the stack pointer: a request that codes it there gets no index term.

Top module: `agu_interlock`

## Requirements
- R1: One clock edge after a request that is accepted (`req_valid_i` high, `stall_o` low), `ea_valid_o` is high and `ea_o` equals base + (index << scale) + displacement, modulo 2^32. In any other cycle `ea_valid_o` is low on the next edge.
- R2: `scale_i` codes 0, 1, 2 and 3 multiply the index term by 1, 2, 4 and 8.
- R3: `disp_sz_i` code 0 adds no displacement. Code 1 adds `disp_i[7:0]` sign-extended to 32 bits. Code 2 adds the whole of `disp_i`. Code 3 is treated like code 0.
- R4: The index term is zero when `idx_valid_i` is low or when `idx_reg_i` is 4, the stack pointer number. Such an index never raises a stall.
- R5: With `mode_wide_i` high, `stall_o` is high in the same cycle as a request whose used base or used index register number equals `prev_dst_i`, provided `prev_wr_i` is high.
- R6: With `mode_wide_i` low, only a base match raises `stall_o`. An index match is ignored, and the request is accepted with its address computed.
- R7: When `prev_wr_i` is low, `stall_o` stays low whatever the register numbers.
- R8: After a stalled request, `ea_valid_o` is low on the next edge and `ea_o` keeps its previous value.
- R9: While `rst_ni` is low, `ea_o` is 0, `ea_valid_o` is 0 and `stall_o` is 0 when no request is present.
- R10: When `base_valid_i` is low, the base term is zero and the base number raises no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| base_valid_i | input | 1 | Base register used |
| base_reg_i | input | 3 | Base register number |
| base_val_i | input | 32 | Base register value |
| idx_valid_i | input | 1 | Index register used |
| idx_reg_i | input | 3 | Index register number (4 = stack pointer, not allowed) |
| idx_val_i | input | 32 | Index register value |
| scale_i | input | 2 | Index shift amount |
| disp_sz_i | input | 2 | Displacement size code |
| disp_i | input | 32 | Displacement value |
| prev_wr_i | input | 1 | Previous instruction writes a register |
| prev_dst_i | input | 3 | Destination of the previous instruction |
| mode_wide_i | input | 1 | 1: check base and index; 0: base only |
| ea_o | output | 32 | Registered effective address |
| ea_valid_o | output | 1 | Registered address-valid strobe |
| stall_o | output | 1 | Interlock stall request, combinational |

## Verification
`stall_o` is combinational, so the bench checks it 1 ns after driving a request on the falling edge, in the same cycle. `ea_o` and `ea_valid_o` pass through one register. They are sampled 1 ns after the next rising edge, and the expected address comes from a model written from R1 to R4. After a stall the same sample point checks that the strobe is low and that the address still holds the last accepted value.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int unsigned AGU_XLEN   = 32;
  localparam int unsigned AGU_NREG   = 8;
  localparam int unsigned AGU_REG_W  = $clog2(AGU_NREG);
  localparam int unsigned AGU_SP_REG = 4;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_BYTE = 2'd1,
    DISP_WORD = 2'd2,
    DISP_RSV  = 2'd3
  } disp_sz_e;
endpackage

// File: rtl/agu_sum.sv
module agu_sum #(
  parameter int unsigned XLEN = agu_pkg::AGU_XLEN
) (
  input  logic            base_use_i,
  input  logic [XLEN-1:0] base_val_i,
  input  logic            idx_use_i,
  input  logic [XLEN-1:0] idx_val_i,
  input  logic [1:0]      scale_i,
  input  logic [1:0]      disp_sz_i,
  input  logic [XLEN-1:0] disp_i,
  output logic [XLEN-1:0] sum_o
);
  import agu_pkg::*;

  logic [XLEN-1:0] base_term, idx_term, disp_term;

  always_comb begin
    base_term = base_use_i ? base_val_i : '0;
    idx_term  = idx_use_i ? (idx_val_i << scale_i) : '0;
    unique case (disp_sz_e'(disp_sz_i))
      DISP_BYTE: disp_term = {{(XLEN-8){disp_i[7]}}, disp_i[7:0]};
      DISP_WORD: disp_term = disp_i;
      default:   disp_term = '0;
    endcase
    sum_o = base_term + idx_term + disp_term;
  end
endmodule

// File: rtl/agu_hazard.sv
module agu_hazard #(
  parameter int unsigned REG_W = agu_pkg::AGU_REG_W,
  parameter int unsigned NSRC  = 2
) (
  input  logic [NSRC-1:0]            src_use_i,
  input  logic [NSRC-1:0][REG_W-1:0] src_reg_i,
  input  logic [NSRC-1:0]            src_chk_i,
  input  logic                       prev_wr_i,
  input  logic [REG_W-1:0]           prev_dst_i,
  output logic                       hit_o
);
  logic [NSRC-1:0] hit_src;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit_src[g] = src_use_i[g] & src_chk_i[g] & (src_reg_i[g] == prev_dst_i);
  end

  assign hit_o = prev_wr_i & (|hit_src);
endmodule

// File: rtl/agu_interlock.sv
module agu_interlock #(
  parameter int unsigned XLEN   = agu_pkg::AGU_XLEN,
  parameter int unsigned NREG   = agu_pkg::AGU_NREG,
  parameter int unsigned SP_REG = agu_pkg::AGU_SP_REG,
  localparam int unsigned REG_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             base_valid_i,
  input  logic [REG_W-1:0] base_reg_i,
  input  logic [XLEN-1:0]  base_val_i,
  input  logic             idx_valid_i,
  input  logic [REG_W-1:0] idx_reg_i,
  input  logic [XLEN-1:0]  idx_val_i,
  input  logic [1:0]       scale_i,
  input  logic [1:0]       disp_sz_i,
  input  logic [XLEN-1:0]  disp_i,
  input  logic             prev_wr_i,
  input  logic [REG_W-1:0] prev_dst_i,
  input  logic             mode_wide_i,
  output logic [XLEN-1:0]  ea_o,
  output logic             ea_valid_o,
  output logic             stall_o
);
  logic            idx_use;
  logic            hit;
  logic            accept;
  logic [XLEN-1:0] sum;

  // stack pointer is not a legal index
  assign idx_use = idx_valid_i & (idx_reg_i != REG_W'(SP_REG));

  agu_sum #(.XLEN(XLEN)) i_sum (
    .base_use_i (base_valid_i),
    .base_val_i (base_val_i),
    .idx_use_i  (idx_use),
    .idx_val_i  (idx_val_i),
    .scale_i    (scale_i),
    .disp_sz_i  (disp_sz_i),
    .disp_i     (disp_i),
    .sum_o      (sum)
  );

  agu_hazard #(.REG_W(REG_W), .NSRC(2)) i_hazard (
    .src_use_i  ({idx_use, base_valid_i}),
    .src_reg_i  ({idx_reg_i, base_reg_i}),
    .src_chk_i  ({mode_wide_i, 1'b1}),
    .prev_wr_i  (prev_wr_i),
    .prev_dst_i (prev_dst_i),
    .hit_o      (hit)
  );

  assign stall_o = req_valid_i & hit;
  assign accept  = req_valid_i & ~hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_o       <= '0;
      ea_valid_o <= 1'b0;
    end else begin
      ea_valid_o <= accept;
      if (accept) ea_o <= sum;
    end
  end
endmodule

// File: rtl/agu_interlock_chk.sv
module agu_interlock_chk #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned REG_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             base_valid_i,
  input logic [REG_W-1:0] base_reg_i,
  input logic             prev_wr_i,
  input logic [REG_W-1:0] prev_dst_i,
  input logic             mode_wide_i,
  input logic [XLEN-1:0]  ea_o,
  input logic             ea_valid_o,
  input logic             stall_o
);
  a_r8_stall_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !ea_valid_o);

  a_r8_hold_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> $stable(ea_o));

  a_r1_strobe_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !stall_o) |=> ea_valid_o);

  a_r1_no_req_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !ea_valid_o);

  a_r7_no_writer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prev_wr_i |-> !stall_o);

  a_r6_narrow_base_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_wide_i && !(base_valid_i && base_reg_i == prev_dst_i)) |-> !stall_o);

  a_r5_base_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && prev_wr_i && base_valid_i && base_reg_i == prev_dst_i) |-> stall_o);

  a_r9_no_req_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !stall_o);
endmodule

bind agu_interlock agu_interlock_chk #(.XLEN(XLEN), .REG_W(REG_W)) i_agu_interlock_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .base_valid_i (base_valid_i),
  .base_reg_i   (base_reg_i),
  .prev_wr_i    (prev_wr_i),
  .prev_dst_i   (prev_dst_i),
  .mode_wide_i  (mode_wide_i),
  .ea_o         (ea_o),
  .ea_valid_o   (ea_valid_o),
  .stall_o      (stall_o)
);

// File: tb/test_agu_interlock.sv
`timescale 1ns/1ps
module test_agu_interlock;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        base_valid_i = 1'b0;
  logic [2:0]  base_reg_i = '0;
  logic [31:0] base_val_i = '0;
  logic        idx_valid_i = 1'b0;
  logic [2:0]  idx_reg_i = '0;
  logic [31:0] idx_val_i = '0;
  logic [1:0]  scale_i = '0;
  logic [1:0]  disp_sz_i = '0;
  logic [31:0] disp_i = '0;
  logic        prev_wr_i = 1'b0;
  logic [2:0]  prev_dst_i = '0;
  logic        mode_wide_i = 1'b0;
  logic [31:0] ea_o;
  logic        ea_valid_o;
  logic        stall_o;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] last_ea = '0;

  always #5 clk_i = ~clk_i;

  agu_interlock i_agu_interlock (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic bv, input logic [31:0] b,
      input logic iv, input logic [2:0] ir, input logic [31:0] x,
      input logic [1:0] sc, input logic [1:0] dsz, input logic [31:0] d);
    logic [31:0] r;
    r = bv ? b : 32'd0;
    if (iv && ir != 3'd4) r = r + x * (32'd1 << sc);
    if (dsz == 2'd1) r = r + {{24{d[7]}}, d[7:0]};
    else if (dsz == 2'd2) r = r + d;
    return r;
  endfunction

  // drive one request, check stall same cycle and result next edge
  task automatic issue(input string tag, input logic bv, input logic [2:0] br, input logic [31:0] b,
      input logic iv, input logic [2:0] ir, input logic [31:0] x,
      input logic [1:0] sc, input logic [1:0] dsz, input logic [31:0] d,
      input logic pw, input logic [2:0] pd, input logic wide, input logic exp_stall);
    logic [31:0] exp_ea;
    @(negedge clk_i);
    req_valid_i = 1'b1; base_valid_i = bv; base_reg_i = br; base_val_i = b;
    idx_valid_i = iv; idx_reg_i = ir; idx_val_i = x; scale_i = sc;
    disp_sz_i = dsz; disp_i = d; prev_wr_i = pw; prev_dst_i = pd; mode_wide_i = wide;
    #1;
    chk({tag, " stall"}, {31'd0, stall_o}, {31'd0, exp_stall});
    exp_ea = exp_stall ? last_ea : model(bv, b, iv, ir, x, sc, dsz, d);
    @(posedge clk_i); #1;
    chk({tag, " valid"}, {31'd0, ea_valid_o}, {31'd0, ~exp_stall});
    chk({tag, " ea"}, ea_o, exp_ea);
    last_ea = exp_ea;
    @(negedge clk_i);
    req_valid_i = 1'b0; prev_wr_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 ea reset", ea_o, 32'd0);
    chk("R9 valid reset", {31'd0, ea_valid_o}, 32'd0);
    chk("R9 stall reset", {31'd0, stall_o}, 32'd0);
  endtask

  task automatic t_sum;
    issue("R1 basic", 1, 3'd1, 32'h1000, 1, 3'd2, 32'h10, 2'd0, 2'd2, 32'h0000_0100, 0, 3'd0, 1, 0);
    issue("R1 wrap", 1, 3'd1, 32'hFFFF_FFF0, 1, 3'd2, 32'h20, 2'd0, 2'd0, 32'h0, 0, 3'd0, 1, 0);
    @(posedge clk_i); #1;
    chk("R1 strobe drops", {31'd0, ea_valid_o}, 32'd0);
  endtask

  task automatic t_scale;
    for (int s = 0; s < 4; s++)
      issue("R2 scale", 1, 3'd0, 32'h100, 1, 3'd3, 32'h3, 2'(s), 2'd0, 32'h0, 0, 3'd0, 1, 0);
  endtask

  task automatic t_disp;
    issue("R3 disp8 neg", 1, 3'd0, 32'h100, 0, 3'd0, 32'h0, 2'd0, 2'd1, 32'h1234_56F0, 0, 3'd0, 1, 0);
    issue("R3 disp8 pos", 1, 3'd0, 32'h100, 0, 3'd0, 32'h0, 2'd0, 2'd1, 32'hFFFF_FF7F, 0, 3'd0, 1, 0);
    issue("R3 disp32", 1, 3'd0, 32'h100, 0, 3'd0, 32'h0, 2'd0, 2'd2, 32'h8000_0000, 0, 3'd0, 1, 0);
    issue("R3 disp none", 1, 3'd0, 32'h100, 0, 3'd0, 32'h0, 2'd0, 2'd0, 32'hDEAD_BEEF, 0, 3'd0, 1, 0);
    issue("R3 disp code3", 1, 3'd0, 32'h100, 0, 3'd0, 32'h0, 2'd0, 2'd3, 32'hDEAD_BEEF, 0, 3'd0, 1, 0);
  endtask

  task automatic t_index;
    issue("R4 idx invalid", 1, 3'd0, 32'h200, 0, 3'd2, 32'h55, 2'd1, 2'd0, 32'h0, 0, 3'd0, 1, 0);
    issue("R4 idx sp", 1, 3'd0, 32'h200, 1, 3'd4, 32'h55, 2'd1, 2'd0, 32'h0, 0, 3'd0, 1, 0);
    issue("R4 idx sp no stall", 1, 3'd0, 32'h200, 1, 3'd4, 32'h55, 2'd1, 2'd0, 32'h0, 1, 3'd4, 1, 0);
  endtask

  task automatic t_conflict;
    issue("R5 wide base", 1, 3'd5, 32'h300, 1, 3'd2, 32'h1, 2'd0, 2'd0, 32'h0, 1, 3'd5, 1, 1);
    issue("R5 wide index", 1, 3'd5, 32'h300, 1, 3'd2, 32'h1, 2'd0, 2'd0, 32'h0, 1, 3'd2, 1, 1);
    issue("R6 narrow index", 1, 3'd5, 32'h300, 1, 3'd2, 32'h1, 2'd2, 2'd0, 32'h0, 1, 3'd2, 0, 0);
    issue("R6 narrow base", 1, 3'd5, 32'h400, 1, 3'd2, 32'h1, 2'd0, 2'd0, 32'h0, 1, 3'd5, 0, 1);
    issue("R7 no writer", 1, 3'd5, 32'h500, 1, 3'd2, 32'h1, 2'd0, 2'd0, 32'h0, 0, 3'd5, 1, 0);
    issue("R10 base invalid", 0, 3'd6, 32'h600, 1, 3'd1, 32'h8, 2'd0, 2'd1, 32'h4, 1, 3'd6, 1, 0);
  endtask

  task automatic t_stall_retry;
    issue("R8 stalled", 1, 3'd7, 32'hA000, 0, 3'd0, 32'h0, 2'd0, 2'd2, 32'h10, 1, 3'd7, 0, 1);
    issue("R8 retry", 1, 3'd7, 32'hB000, 0, 3'd0, 32'h0, 2'd0, 2'd2, 32'h10, 0, 3'd7, 0, 0);
  endtask

  initial begin : watchdog
    #1ms;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset;
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_sum;
    t_scale;
    t_disp;
    t_index;
    t_conflict;
    t_stall_retry;
    repeat (2) @(posedge clk_i);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule